// File: doc/BRIEF.md
# Incremental LDL Factor Update Engine

This engine keeps a growing unit-lower-triangular factor `L` and a diagonal `D` such that `L·D·Lᵀ` equals the Gram matrix of the atoms chosen so far by a greedy sparse-recovery loop. Each time the loop picks a new atom, it streams in that atom's inner products with every atom already active, followed by the atom's inner product with itself. The engine adds one row to `L` and one entry to `D`. Entries from earlier iterations are never recomputed. No square root is taken at any point.

With the same column it receives a scalar, the correlation of the previous residual with the new atom. The right-hand side of the direction system is zero everywhere except in its newest position. The forward pass of that solve therefore shrinks to a single division by the new diagonal entry. One backward pass through `Lᵀ` then yields the full update direction. The direction is streamed out from the newest index down to index 0, and a completion pulse follows.

All arithmetic is signed fixed point with `W` bits and `F` fractional bits. One sequential divider is shared by the row computation and the direction computation.

Top module: `ldl_update_engine`

## Requirements
- R1: While `rst` is high and after it falls, `active_cnt` is 0, `fact_err` is 0, `dir_valid` and `done` are 0, and `col_ready` is 1.
- R2: A beat is taken only in a cycle with `col_valid` and `col_ready` both high. With `n = active_cnt`, the first `n` beats (`col_last`=0) carry the cross products g[0..n-1]. The beat with `col_last`=1 carries the self product s and also samples `corr_data` as c. Beats while `col_ready` is low have no effect on outputs or state.
- R3: When `active_cnt` is 0, the new diagonal entry is s and no row of L is produced. If s > 0, exactly one direction value is emitted: index 0, value fxdiv(c, s).
- R4: For n > 0, z[i] = g[i] − Σ_{j<i} fxmul(L[i][j], z[j]) and l[i] = fxdiv(z[i], D[i]). Here fxmul(a,b) = (a·b) arithmetically shifted right by F (floor), fxdiv(a,b) = a·2^F / b truncated toward zero, and every sum wraps modulo 2^W.
- R5: The new diagonal value is d = s − Σ fxmul(z[i], l[i]). If d > 0 (signed), row n of L becomes l, D[n] becomes d, and `active_cnt` increments by exactly one. `active_cnt` never changes otherwise, except at reset.
- R6: If d ≤ 0, `fact_err` is set and stays set until reset. The column is discarded and `active_cnt` is unchanged. No direction value is emitted, and `done` still pulses.
- R7: The direction is dir[n] = fxdiv(c, d), then dir[i] = −Σ_{j=i+1..n} fxmul(L[j][i], dir[j]) for i = n−1 down to 0. Each value appears with one `dir_valid` cycle, with `dir_idx` taking the values n, n−1, …, 0 in that order.
- R8: `done` is high for exactly one cycle. It comes in the cycle right after the `dir_valid` cycle with `dir_idx`=0, or after a rejected column, and it never coincides with `dir_valid`.
- R9: When `active_cnt` equals K, `col_ready` is low and column beats are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the factor |
| col_valid | input | 1 | Column beat present |
| col_data | input | W | Cross or self inner product, fixed point |
| col_last | input | 1 | Marks the self-product beat that ends a column |
| corr_data | input | W | Residual correlation, sampled with the last beat |
| col_ready | output | 1 | Engine idle with room for another column |
| dir_valid | output | 1 | Direction element present |
| dir_idx | output | clog2(K) | Index of the direction element |
| dir_data | output | W | Direction element value |
| done | output | 1 | One-cycle end-of-iteration pulse |
| fact_err | output | 1 | Sticky non-positive pivot flag |
| active_cnt | output | clog2(K+1) | Number of committed columns |

## Verification
Each stored entry of L or D feeds every later forward pass and every backward pass. A corrupted entry, a wrong rounding, or a swapped index therefore shows up in the direction values. It appears either in the same iteration, through the backward pass over row n, or in the first later column that reads the entry. A wrong pivot decision shows at once in `fact_err` and `active_cnt`, and in how many direction beats come out. Random Gram columns built from small integer atoms are checked against a bit-exact model. Zero atoms, repeated atoms, a first-column rejection and a full factor are added as directed cases.

// File: rtl/ldl_pkg.sv
package ldl_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FS_ROW,
        S_FS_MAC,
        S_FS_DIV,
        S_CHECK,
        S_C_DIV,
        S_BS_ROW,
        S_BS_MAC,
        S_DONE
    } ldl_state_e;

    // first linear slot of row `row` in a packed strictly-lower triangle
    function automatic int tri_base(input int row);
        return (row * (row - 1)) / 2;
    endfunction

endpackage

// File: rtl/ldl_mac.sv
module ldl_mac #(
    parameter int W = 32,
    parameter int F = 16
) (
    input  logic signed [W-1:0] acc_in,
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    output logic signed [W-1:0] acc_out
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] wide_a;
    logic signed [PW-1:0] wide_b;
    logic signed [PW-1:0] prod;

    assign wide_a  = {{W{op_a[W-1]}}, op_a};
    assign wide_b  = {{W{op_b[W-1]}}, op_b};
    assign prod    = wide_a * wide_b;
    // floor-scaled product, subtracted with W-bit wrap
    assign acc_out = acc_in - W'(prod >>> F);

endmodule

// File: rtl/ldl_seq_div.sv
module ldl_seq_div #(
    parameter int W = 32,
    parameter int F = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic signed [W-1:0] num,
    input  logic signed [W-1:0] den,
    output logic                done,
    output logic signed [W-1:0] quo
);
    localparam int NB = W + F;
    localparam int CW = $clog2(NB + 1);

    logic [NB-1:0] dvd;
    logic [W-1:0]  dmag;
    logic [W-1:0]  rem;
    logic [CW-1:0] left;
    logic          neg;
    logic          busy;

    logic [W-1:0]  num_mag;
    logic [W-1:0]  den_mag;
    logic [W:0]    rem_sh;
    logic          fits;

    assign num_mag = num[W-1] ? W'(-num) : W'(num);
    assign den_mag = den[W-1] ? W'(-den) : W'(den);
    assign rem_sh  = {rem, dvd[NB-1]};
    assign fits    = rem_sh >= {1'b0, dmag};
    assign quo     = neg ? $signed(W'(-dvd[W-1:0])) : $signed(dvd[W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd  <= '0;
            dmag <= '0;
            rem  <= '0;
            left <= '0;
            neg  <= 1'b0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                dvd  <= {num_mag, {F{1'b0}}};
                dmag <= den_mag;
                rem  <= '0;
                left <= CW'(NB);
                neg  <= num[W-1] ^ den[W-1];
                busy <= 1'b1;
            end else if (busy) begin
                rem  <= fits ? W'(rem_sh - {1'b0, dmag}) : rem_sh[W-1:0];
                dvd  <= {dvd[NB-2:0], fits};
                left <= left - CW'(1);
                if (left == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ldl_factor_mem.sv
module ldl_factor_mem
    import ldl_pkg::*;
#(
    parameter int W = 32,
    parameter int K = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      l_we,
    input  logic [$clog2(K)-1:0]      l_row,
    input  logic [$clog2(K)-1:0]      l_col,
    input  logic signed [W-1:0]       l_wdata,
    input  logic                      d_we,
    input  logic [$clog2(K)-1:0]      d_idx,
    input  logic signed [W-1:0]       d_wdata,
    input  logic [$clog2(K)-1:0]      rd_row,
    input  logic [$clog2(K)-1:0]      rd_col,
    output logic signed [W-1:0]       l_rdata,
    input  logic [$clog2(K)-1:0]      rd_didx,
    output logic signed [W-1:0]       d_rdata
);
    localparam int NL = (K * (K - 1)) / 2;
    localparam int LW = $clog2(NL);

    logic signed [W-1:0] lmem [NL];
    logic signed [W-1:0] dmem [K];

    int wr_lin;
    int rd_lin;

    assign wr_lin  = tri_base(int'(l_row)) + int'(l_col);
    assign rd_lin  = tri_base(int'(rd_row)) + int'(rd_col);
    assign l_rdata = (rd_lin < NL) ? lmem[LW'(rd_lin)] : '0;
    assign d_rdata = dmem[rd_didx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NL; i++) lmem[i] <= '0;
            for (int i = 0; i < K; i++)  dmem[i] <= '0;
        end else begin
            if (l_we && (wr_lin < NL)) lmem[LW'(wr_lin)] <= l_wdata;
            if (d_we)                  dmem[d_idx]       <= d_wdata;
        end
    end

endmodule

// File: rtl/ldl_update_engine.sv
module ldl_update_engine
    import ldl_pkg::*;
#(
    parameter int W = 32,
    parameter int F = 16,
    parameter int K = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      col_valid,
    input  logic [W-1:0]              col_data,
    input  logic                      col_last,
    input  logic [W-1:0]              corr_data,
    output logic                      col_ready,
    output logic                      dir_valid,
    output logic [$clog2(K)-1:0]      dir_idx,
    output logic [W-1:0]              dir_data,
    output logic                      done,
    output logic                      fact_err,
    output logic [$clog2(K+1)-1:0]    active_cnt
);
    localparam int IW = $clog2(K + 1);
    localparam int XW = $clog2(K);

    ldl_state_e st;

    logic [IW-1:0]       n_cur, ptr, ri, rj;
    logic signed [W-1:0] gbuf [K];
    logic signed [W-1:0] zbuf [K];
    logic signed [W-1:0] dbuf [K];
    logic signed [W-1:0] corr_r, acc, dacc;

    // shared datapath wires
    logic [IW-1:0]       rd_row, rd_col;
    logic signed [W-1:0] l_rdata, d_rdata;
    logic signed [W-1:0] mac_b, mac_res, piv_res;
    logic                div_start, div_done;
    logic signed [W-1:0] div_num, div_den, div_quo;
    logic                d22_ok, l_we, d_we;

    assign col_ready = (st == S_IDLE) && (active_cnt < IW'(K));
    assign d22_ok    = !dacc[W-1] && (dacc != '0);

    always_comb begin
        if (st == S_BS_MAC) begin
            rd_row = rj;
            rd_col = ri;
            mac_b  = dbuf[XW'(rj)];
        end else begin
            rd_row = ri;
            rd_col = rj;
            mac_b  = zbuf[XW'(rj)];
        end
    end

    always_comb begin
        div_start = 1'b0;
        div_num   = acc;
        div_den   = d_rdata;
        if (st == S_FS_MAC && rj == ri) begin
            div_start = 1'b1;
        end else if (st == S_CHECK) begin
            div_start = d22_ok;
            div_num   = corr_r;
            div_den   = dacc;
        end
    end

    assign l_we = (st == S_FS_DIV) && div_done;
    assign d_we = (st == S_CHECK) && d22_ok;

    ldl_factor_mem #(.W(W), .K(K)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .l_we    (l_we),
        .l_row   (XW'(n_cur)),
        .l_col   (XW'(ri)),
        .l_wdata (div_quo),
        .d_we    (d_we),
        .d_idx   (XW'(n_cur)),
        .d_wdata (dacc),
        .rd_row  (XW'(rd_row)),
        .rd_col  (XW'(rd_col)),
        .l_rdata (l_rdata),
        .rd_didx (XW'(ri)),
        .d_rdata (d_rdata)
    );

    ldl_mac #(.W(W), .F(F)) u_mac_row (
        .acc_in  (acc),
        .op_a    (l_rdata),
        .op_b    (mac_b),
        .acc_out (mac_res)
    );

    ldl_mac #(.W(W), .F(F)) u_mac_piv (
        .acc_in  (dacc),
        .op_a    (zbuf[XW'(ri)]),
        .op_b    (div_quo),
        .acc_out (piv_res)
    );

    ldl_seq_div #(.W(W), .F(F)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            active_cnt <= '0;
            n_cur      <= '0;
            ptr        <= '0;
            ri         <= '0;
            rj         <= '0;
            corr_r     <= '0;
            acc        <= '0;
            dacc       <= '0;
            fact_err   <= 1'b0;
            dir_valid  <= 1'b0;
            dir_idx    <= '0;
            dir_data   <= '0;
            done       <= 1'b0;
            for (int i = 0; i < K; i++) begin
                gbuf[i] <= '0;
                zbuf[i] <= '0;
                dbuf[i] <= '0;
            end
        end else begin
            dir_valid <= 1'b0;
            done      <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (col_valid && col_ready) begin
                        if (col_last) begin
                            corr_r <= corr_data;
                            dacc   <= col_data;
                            n_cur  <= active_cnt;
                            ri     <= '0;
                            ptr    <= '0;
                            st     <= (active_cnt == '0) ? S_CHECK : S_FS_ROW;
                        end else if (ptr < IW'(K)) begin
                            gbuf[XW'(ptr)] <= col_data;
                            ptr            <= ptr + IW'(1);
                        end
                    end
                end
                S_FS_ROW: begin
                    acc <= gbuf[XW'(ri)];
                    rj  <= '0;
                    st  <= S_FS_MAC;
                end
                S_FS_MAC: begin
                    if (rj < ri) begin
                        acc <= mac_res;
                        rj  <= rj + IW'(1);
                    end else begin
                        zbuf[XW'(ri)] <= acc;
                        st            <= S_FS_DIV;
                    end
                end
                S_FS_DIV: begin
                    if (div_done) begin
                        dacc <= piv_res;
                        ri   <= ri + IW'(1);
                        st   <= (ri + IW'(1) == n_cur) ? S_CHECK : S_FS_ROW;
                    end
                end
                S_CHECK: begin
                    if (d22_ok) begin
                        active_cnt <= active_cnt + IW'(1);
                        st         <= S_C_DIV;
                    end else begin
                        fact_err <= 1'b1;
                        st       <= S_DONE;
                    end
                end
                S_C_DIV: begin
                    if (div_done) begin
                        dbuf[XW'(n_cur)] <= div_quo;
                        dir_valid        <= 1'b1;
                        dir_idx          <= XW'(n_cur);
                        dir_data         <= div_quo;
                        if (n_cur == '0) begin
                            st <= S_DONE;
                        end else begin
                            ri <= n_cur - IW'(1);
                            st <= S_BS_ROW;
                        end
                    end
                end
                S_BS_ROW: begin
                    acc <= '0;
                    rj  <= ri + IW'(1);
                    st  <= S_BS_MAC;
                end
                S_BS_MAC: begin
                    if (rj <= n_cur) begin
                        acc <= mac_res;
                        rj  <= rj + IW'(1);
                    end else begin
                        dbuf[XW'(ri)] <= acc;
                        dir_valid     <= 1'b1;
                        dir_idx       <= XW'(ri);
                        dir_data      <= acc;
                        if (ri == '0) begin
                            st <= S_DONE;
                        end else begin
                            ri <= ri - IW'(1);
                            st <= S_BS_ROW;
                        end
                    end
                end
                S_DONE: begin
                    done <= 1'b1;
                    st   <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ldl_update_engine_chk.sv
module ldl_update_engine_chk #(
    parameter int K  = 8,
    parameter int IW = 4,
    parameter int XW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          col_ready,
    input logic          dir_valid,
    input logic [XW-1:0] dir_idx,
    input logic          done,
    input logic          fact_err,
    input logic [IW-1:0] active_cnt
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (active_cnt == '0 && !fact_err && !dir_valid && !done)); // R1

    AST_NO_TAKE_WHILE_EMIT: assert property (@(posedge clk) disable iff (rst)
        dir_valid |-> !col_ready); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (active_cnt == $past(active_cnt) ||
                  active_cnt == $past(active_cnt) + IW'(1))); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        fact_err |=> fact_err); // R6

    AST_DONE_AFTER_IDX0: assert property (@(posedge clk) disable iff (rst)
        (dir_valid && dir_idx == '0) |=> done); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        done |-> !dir_valid); // R8

    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        active_cnt <= IW'(K)); // R9

    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (active_cnt == IW'(K)) |-> !col_ready); // R9

endmodule

bind ldl_update_engine ldl_update_engine_chk #(.K(K), .IW(IW), .XW(XW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .col_ready  (col_ready),
    .dir_valid  (dir_valid),
    .dir_idx    (dir_idx),
    .done       (done),
    .fact_err   (fact_err),
    .active_cnt (active_cnt)
);

// File: tb/ldl_update_engine_tb.sv
module ldl_update_engine_tb;
    localparam int W  = 32;
    localparam int F  = 16;
    localparam int K  = 8;
    localparam int M  = 8;
    localparam int IW = $clog2(K + 1);
    localparam int XW = $clog2(K);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          col_valid = 1'b0;
    logic [W-1:0]  col_data = '0;
    logic          col_last = 1'b0;
    logic [W-1:0]  corr_data = '0;
    logic          col_ready;
    logic          dir_valid;
    logic [XW-1:0] dir_idx;
    logic [W-1:0]  dir_data;
    logic          done;
    logic          fact_err;
    logic [IW-1:0] active_cnt;

    always #4 clk = ~clk;

    ldl_update_engine #(.W(W), .F(F), .K(K)) u_dut (
        .clk(clk), .rst(rst), .col_valid(col_valid), .col_data(col_data),
        .col_last(col_last), .corr_data(corr_data), .col_ready(col_ready),
        .dir_valid(dir_valid), .dir_idx(dir_idx), .dir_data(dir_data),
        .done(done), .fact_err(fact_err), .active_cnt(active_cnt)
    );

    int nvec  = 0;
    int nfail = 0;

    // bit-exact reference state
    int Lm [K][K];
    int Dm [K];
    int act [K][M];
    int cntm;
    int errm;

    task automatic chk(input bit ok, input string req, input string what,
                       input int actual, input int expected);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    function automatic int fxm(input int a, input int b);
        longint p;
        p = longint'(a) * longint'(b);
        return int'(p >>> F);
    endfunction

    function automatic int fxd(input int a, input int b);
        longint q;
        q = (longint'(a) <<< F) / longint'(b);
        return int'(q);
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        col_valid = 1'b0;
        repeat (2) @(negedge clk);
        // R1: state while reset is held
        chk(col_ready == 1'b1, "R1", "col_ready in reset", int'(col_ready), 1);
        chk(active_cnt == '0, "R1", "active_cnt in reset", int'(active_cnt), 0);
        chk(fact_err == 1'b0 && dir_valid == 1'b0 && done == 1'b0, "R1",
            "err/valid/done in reset", int'({fact_err, dir_valid, done}), 0);
        rst = 1'b0;
        cntm = 0;
        errm = 0;
        for (int i = 0; i < K; i++) begin
            Dm[i] = 0;
            for (int j = 0; j < K; j++) Lm[i][j] = 0;
        end
        @(negedge clk);
        chk(active_cnt == '0 && col_ready == 1'b1, "R1", "state after reset",
            int'(active_cnt), 0);
    endtask

    task automatic run_col(input int atom [M], input int c, input bit junk);
        int g [K];
        int z [K];
        int l [K];
        int dv [K];
        int ev [K];
        int ei [K];
        int n, s, d, acc, exp_n, got, cyc, last_cyc;
        bit seen_done;
        string rq;

        n = cntm;
        s = 0;
        for (int e = 0; e < M; e++) s += atom[e] * atom[e];
        s = s <<< F;
        for (int i = 0; i < n; i++) begin
            g[i] = 0;
            for (int e = 0; e < M; e++) g[i] += act[i][e] * atom[e];
            g[i] = g[i] <<< F;
        end

        // reference: new row, pivot, direction (R4, R5, R7)
        d = s;
        for (int i = 0; i < n; i++) begin
            acc = g[i];
            for (int j = 0; j < i; j++) acc -= fxm(Lm[i][j], z[j]);
            z[i] = acc;
            l[i] = fxd(acc, Dm[i]);
            d -= fxm(acc, l[i]);
        end
        exp_n = 0;
        if (d <= 0) begin
            errm = 1;
        end else begin
            for (int i = 0; i < n; i++) Lm[n][i] = l[i];
            Dm[n] = d;
            for (int e = 0; e < M; e++) act[n][e] = atom[e];
            cntm++;
            dv[n] = fxd(c, d);
            for (int i = n - 1; i >= 0; i--) begin
                acc = 0;
                for (int j = i + 1; j <= n; j++) acc -= fxm(Lm[j][i], dv[j]);
                dv[i] = acc;
            end
            exp_n = n + 1;
            for (int k = 0; k <= n; k++) begin
                ei[k] = n - k;
                ev[k] = dv[n - k];
            end
        end
        rq = (n == 0) ? "R3" : "R7";

        chk(col_ready == 1'b1, "R2", "ready before column", int'(col_ready), 1);
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            col_valid = 1'b1;
            col_last  = 1'b0;
            col_data  = g[b];
        end
        @(negedge clk);
        col_valid = 1'b1;
        col_last  = 1'b1;
        col_data  = s;
        corr_data = c;

        got = 0;
        cyc = 0;
        last_cyc = -10;
        seen_done = 1'b0;
        while (!seen_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            // R2: junk beats while busy must be ignored
            col_valid = junk && (cyc <= 3);
            col_last  = 1'b1;
            col_data  = 32'h0013_0000;
            corr_data = 32'h7fff_0000;
            if (dir_valid) begin
                if (got < exp_n) begin
                    chk(int'(dir_idx) == ei[got], rq, "dir_idx", int'(dir_idx), ei[got]);
                    chk($signed(dir_data) == ev[got], rq, "dir_data",
                        $signed(dir_data), ev[got]);
                end
                got++;
                last_cyc = cyc;
            end
            if (done) begin
                seen_done = 1'b1;
                if (exp_n > 0)
                    chk(cyc == last_cyc + 1, "R8", "done one cycle after idx 0",
                        cyc - last_cyc, 1);
            end
        end
        col_valid = 1'b0;
        col_last  = 1'b0;
        chk(seen_done, "R8", "done pulse seen", int'(seen_done), 1);
        chk(got == exp_n, (d <= 0) ? "R6" : rq, "direction beat count", got, exp_n);
        chk(int'(fact_err) == errm, (d <= 0) ? "R6" : "R5", "fact_err", int'(fact_err), errm);
        chk(int'(active_cnt) == cntm, "R5", "active_cnt", int'(active_cnt), cntm);
    endtask

    task automatic capacity_probe();
        // R9: factor full, beats ignored
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(col_ready == 1'b0, "R9", "col_ready when full", int'(col_ready), 0);
            col_valid = 1'b1;
            col_last  = 1'b1;
            col_data  = 32'h0040_0000;
        end
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            col_valid = 1'b0;
            if (dir_valid || done)
                chk(1'b0, "R9", "output after ignored beat", 1, 0);
        end
        chk(int'(active_cnt) == K, "R9", "active_cnt stays full", int'(active_cnt), K);
    endtask

    initial begin
        int unsigned seed_sink;
        int atom [M];
        int c, guard;
        seed_sink = $urandom(32'd20240611);
        for (int p = 0; p < 5; p++) begin
            do_reset();
            guard = 0;
            while (cntm < K && guard < 3 * K) begin
                for (int e = 0; e < M; e++) atom[e] = int'($urandom_range(8)) - 4;
                // directed corners
                if (p == 2 && guard == 0)
                    for (int e = 0; e < M; e++) atom[e] = 0;       // first-column reject (R3, R6)
                if (p == 1 && guard == 3)
                    for (int e = 0; e < M; e++) atom[e] = 0;       // mid-run reject (R6)
                if (p == 3 && guard == 2 && cntm > 0)
                    for (int e = 0; e < M; e++) atom[e] = act[0][e]; // repeated atom
                c = (int'($urandom_range(128)) - 64) <<< F;
                if (p == 0 && guard == 0) c = -(5 <<< F);
                run_col(atom, c, (guard % 3) == 1);
                guard++;
            end
            if (cntm == K) capacity_probe();
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule